// File: doc/BRIEF.md
# ModR/M and SIB Operand Parser

This block sits behind the opcode stage of a 64-bit instruction decoder. It receives the operand-specifier bytes one per clock under a valid/ready handshake, starting at the ModR/M byte. From that byte it works out whether the operand is a register or a memory reference. For a memory reference it also works out whether a scale-index-base (SIB) byte follows and whether the displacement is 0, 1 or 4 bytes long. It takes in exactly those bytes and then presents a single decoded operand descriptor. The descriptor carries a register/memory flag, the base and index registers with their presence flags, the scale, a RIP-relative flag, a displacement sign-extended to 64 bits and the total number of bytes consumed.

Some register numbers in the ModR/M and SIB fields do not name a register. They are escape codes that mean "a SIB byte follows", "no base register" or "no index register", and the parser resolves them. The descriptor is held until the consumer accepts it. No new byte is taken while the descriptor is held. The parser waits for the next ModR/M byte on the cycle after acceptance.

Top module: `mrm_parser`

## Requirements
- R1: After reset, in_ready is 1 and desc_valid is 0.
- R2: A ModR/M byte (mod = bits 7:6, reg = bits 5:3 and ignored, rm = bits 2:0) with mod=11 gives a register descriptor: is_reg=1, base_vld=1, base_num=rm, idx_vld=0, idx_num=0, scale=1, rip_rel=0, disp=0, length 1.
- R3: A memory form with rm other than 100, and other than 101 when mod=00, gives base_vld=1 and base_num=rm, with no index and scale 1. It takes 0, 1 or 4 displacement bytes for mod 00, 01 or 10, and its length is 1 plus the displacement bytes.
- R4: mod=00 with rm=101 gives rip_rel=1, no base and no index, a 4-byte displacement, and length 5.
- R5: A memory form with rm=100 takes one SIB byte (scale code = bits 7:6, index = bits 5:3, base = bits 2:0). Scale codes 00/01/10/11 are reported as 1/2/4/8. An index field of 100 gives idx_vld=0 and idx_num=0; any other value gives idx_vld=1 and idx_num equal to the field. Length is 2 plus the displacement bytes.
- R6: With a SIB byte, mod=00 and SIB base field 101 give base_vld=0 and base_num=0, followed by a 4-byte displacement. Length is 6.
- R7: mod=01 with rm=101 names base register 5 with a 1-byte displacement, and this includes a displacement of zero.
- R8: Displacement bytes arrive least significant first. A 1-byte displacement is sign-extended from bit 7 and a 4-byte displacement from bit 31, both to 64 bits. Forms without a displacement report 0.
- R9: While desc_valid=1 and desc_ready=0, every descriptor field holds its value and in_ready stays 0.
- R10: A cycle with desc_valid=1 and desc_ready=1 is followed by desc_valid=0 and in_ready=1, and the next byte is taken as a new ModR/M byte.
- R11: A cycle with in_valid=0 consumes no byte and does not advance the parse, whatever value in_byte has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_byte carries a byte |
| in_ready | output | 1 | Parser takes in_byte this cycle |
| in_byte | input | 8 | Operand-specifier byte |
| desc_valid | output | 1 | Descriptor is available |
| desc_ready | input | 1 | Consumer accepts the descriptor |
| desc_is_reg | output | 1 | Operand is a register |
| desc_rip_rel | output | 1 | Address is relative to the next instruction pointer |
| desc_base_vld | output | 1 | A base register is used |
| desc_base_num | output | REG_W | Base register number (register operand number when is_reg) |
| desc_idx_vld | output | 1 | An index register is used |
| desc_idx_num | output | REG_W | Index register number |
| desc_scale | output | 4 | Index scale: 1, 2, 4 or 8 |
| desc_disp | output | DISP_W | Sign-extended displacement |
| desc_len | output | CNT_W | Bytes consumed: ModR/M, SIB and displacement |

## Verification
Every descriptor field is a register that loads at the clock edge that accepts the last byte of the form. It is therefore due at the first falling edge after that byte is accepted. The bench drives bytes at falling edges and samples all outputs at falling edges, so each check lands one half-period after the edge that should have produced the value. The release of the descriptor is checked one edge after desc_ready is raised: at that point desc_valid must be 0 and in_ready must be 1. Idle gaps with junk on in_byte and held descriptors are mixed into the sweep, so the timing is also checked under stalls on both sides.

// File: rtl/mrm_pkg.sv
package mrm_pkg;

  typedef enum logic [1:0] {
    ST_MODRM,
    ST_SIB,
    ST_DISP,
    ST_OUT
  } mrm_state_e;

  localparam logic [1:0] MOD_NODISP = 2'b00;
  localparam logic [1:0] MOD_DISP8  = 2'b01;
  localparam logic [1:0] MOD_DISP32 = 2'b10;
  localparam logic [1:0] MOD_REG    = 2'b11;

  // Field values that act as escapes instead of naming a register
  localparam logic [2:0] RM_ESC_SIB    = 3'b100;
  localparam logic [2:0] RM_ESC_NOBASE = 3'b101;
  localparam logic [2:0] IX_ESC_NONE   = 3'b100;

  localparam int DISP32_BYTES = 4;

  function automatic logic [2:0] disp_bytes_for_mod(input logic [1:0] mod);
    case (mod)
      MOD_DISP8:  return 3'd1;
      MOD_DISP32: return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/mrm_modrm_decode.sv
module mrm_modrm_decode
  import mrm_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic [7:0]       modrm_i,
  output logic             is_reg_o,
  output logic             need_sib_o,
  output logic             rip_rel_o,
  output logic             base_vld_o,
  output logic [REG_W-1:0] base_num_o,
  output logic [2:0]       disp_len_o
);

  logic [1:0] mod_f;
  logic [2:0] rm_f;

  assign mod_f = modrm_i[7:6];
  assign rm_f  = modrm_i[2:0];

  always_comb begin
    is_reg_o   = 1'b0;
    need_sib_o = 1'b0;
    rip_rel_o  = 1'b0;
    base_vld_o = 1'b0;
    base_num_o = '0;
    disp_len_o = disp_bytes_for_mod(mod_f);
    if (mod_f == MOD_REG) begin
      is_reg_o   = 1'b1;
      base_vld_o = 1'b1;
      base_num_o = REG_W'(rm_f);
      disp_len_o = 3'd0;
    end else if (rm_f == RM_ESC_SIB) begin
      // base and index come from the SIB byte
      need_sib_o = 1'b1;
    end else if (mod_f == MOD_NODISP && rm_f == RM_ESC_NOBASE) begin
      rip_rel_o  = 1'b1;
      disp_len_o = 3'(DISP32_BYTES);
    end else begin
      base_vld_o = 1'b1;
      base_num_o = REG_W'(rm_f);
    end
  end

endmodule

// File: rtl/mrm_sib_decode.sv
module mrm_sib_decode
  import mrm_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic [7:0]       sib_i,
  input  logic [1:0]       mod_i,
  output logic             idx_vld_o,
  output logic [REG_W-1:0] idx_num_o,
  output logic [3:0]       scale_o,
  output logic             base_vld_o,
  output logic [REG_W-1:0] base_num_o,
  output logic [2:0]       disp_len_o
);

  logic [1:0] ss_f;
  logic [2:0] ix_f;
  logic [2:0] bs_f;

  assign ss_f = sib_i[7:6];
  assign ix_f = sib_i[5:3];
  assign bs_f = sib_i[2:0];

  assign scale_o = 4'b0001 << ss_f;

  always_comb begin
    idx_vld_o = (ix_f != IX_ESC_NONE);
    idx_num_o = idx_vld_o ? REG_W'(ix_f) : '0;
  end

  always_comb begin
    if (mod_i == MOD_NODISP && bs_f == RM_ESC_NOBASE) begin
      base_vld_o = 1'b0;
      base_num_o = '0;
      disp_len_o = 3'(DISP32_BYTES);
    end else begin
      base_vld_o = 1'b1;
      base_num_o = REG_W'(bs_f);
      disp_len_o = disp_bytes_for_mod(mod_i);
    end
  end

endmodule

// File: rtl/mrm_disp_accum.sv
module mrm_disp_accum #(
  parameter int DISP_W = 64,
  parameter int LANE_W = $clog2(DISP_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [7:0]        byte_i,
  output logic [DISP_W-1:0] disp_o
);

  localparam int LANES = DISP_W / 8;

  logic [7:0] lane_q [LANES];

  // Each byte lands in its lane; all higher lanes take its sign, so the
  // value is sign-extended correctly after whichever byte is the last.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        lane_q[g] <= '0;
      end else if (load_i) begin
        if (LANE_W'(g) == lane_i) begin
          lane_q[g] <= byte_i;
        end else if (LANE_W'(g) > lane_i) begin
          lane_q[g] <= {8{byte_i[7]}};
        end
      end
    end
    assign disp_o[g*8 +: 8] = lane_q[g];
  end

endmodule

// File: rtl/mrm_parser.sv
module mrm_parser
  import mrm_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int DISP_W = 64,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic              desc_is_reg,
  output logic              desc_rip_rel,
  output logic              desc_base_vld,
  output logic [REG_W-1:0]  desc_base_num,
  output logic              desc_idx_vld,
  output logic [REG_W-1:0]  desc_idx_num,
  output logic [3:0]        desc_scale,
  output logic [DISP_W-1:0] desc_disp,
  output logic [CNT_W-1:0]  desc_len
);

  localparam int LANE_W = $clog2(DISP_W / 8);

  mrm_state_e       state_q;
  logic [1:0]       mod_q;
  logic             is_reg_q, rip_q, base_vld_q, idx_vld_q;
  logic [REG_W-1:0] base_q, idx_q;
  logic [3:0]       scale_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       left_q;
  logic [LANE_W-1:0] lane_q;

  logic take;

  // ModR/M field decode
  logic             m_is_reg, m_need_sib, m_rip, m_base_vld;
  logic [REG_W-1:0] m_base;
  logic [2:0]       m_len;

  // SIB field decode
  logic             s_idx_vld, s_base_vld;
  logic [REG_W-1:0] s_idx, s_base;
  logic [3:0]       s_scale;
  logic [2:0]       s_len;

  assign in_ready   = (state_q != ST_OUT);
  assign desc_valid = (state_q == ST_OUT);
  assign take       = in_valid && in_ready;

  mrm_modrm_decode #(.REG_W(REG_W)) u_modrm (
    .modrm_i    (in_byte),
    .is_reg_o   (m_is_reg),
    .need_sib_o (m_need_sib),
    .rip_rel_o  (m_rip),
    .base_vld_o (m_base_vld),
    .base_num_o (m_base),
    .disp_len_o (m_len)
  );

  mrm_sib_decode #(.REG_W(REG_W)) u_sib (
    .sib_i      (in_byte),
    .mod_i      (mod_q),
    .idx_vld_o  (s_idx_vld),
    .idx_num_o  (s_idx),
    .scale_o    (s_scale),
    .base_vld_o (s_base_vld),
    .base_num_o (s_base),
    .disp_len_o (s_len)
  );

  mrm_disp_accum #(.DISP_W(DISP_W), .LANE_W(LANE_W)) u_disp (
    .clk     (clk),
    .rst     (rst),
    .clear_i (take && state_q == ST_MODRM),
    .load_i  (take && state_q == ST_DISP),
    .lane_i  (lane_q),
    .byte_i  (in_byte),
    .disp_o  (desc_disp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_MODRM;
      mod_q      <= '0;
      is_reg_q   <= 1'b0;
      rip_q      <= 1'b0;
      base_vld_q <= 1'b0;
      base_q     <= '0;
      idx_vld_q  <= 1'b0;
      idx_q      <= '0;
      scale_q    <= 4'd1;
      cnt_q      <= '0;
      left_q     <= '0;
      lane_q     <= '0;
    end else begin
      case (state_q)
        ST_MODRM: if (take) begin
          mod_q      <= in_byte[7:6];
          is_reg_q   <= m_is_reg;
          rip_q      <= m_rip;
          base_vld_q <= m_base_vld;
          base_q     <= m_base;
          idx_vld_q  <= 1'b0;
          idx_q      <= '0;
          scale_q    <= 4'd1;
          cnt_q      <= CNT_W'(1);
          lane_q     <= '0;
          left_q     <= m_len;
          if (m_need_sib)         state_q <= ST_SIB;
          else if (m_len != 3'd0) state_q <= ST_DISP;
          else                    state_q <= ST_OUT;
        end
        ST_SIB: if (take) begin
          idx_vld_q  <= s_idx_vld;
          idx_q      <= s_idx;
          scale_q    <= s_scale;
          base_vld_q <= s_base_vld;
          base_q     <= s_base;
          cnt_q      <= cnt_q + CNT_W'(1);
          left_q     <= s_len;
          state_q    <= (s_len != 3'd0) ? ST_DISP : ST_OUT;
        end
        ST_DISP: if (take) begin
          cnt_q  <= cnt_q + CNT_W'(1);
          lane_q <= lane_q + LANE_W'(1);
          left_q <= left_q - 3'd1;
          if (left_q == 3'd1) state_q <= ST_OUT;
        end
        ST_OUT: if (desc_ready) state_q <= ST_MODRM;
        default: state_q <= ST_MODRM;
      endcase
    end
  end

  assign desc_is_reg   = is_reg_q;
  assign desc_rip_rel  = rip_q;
  assign desc_base_vld = base_vld_q;
  assign desc_base_num = base_q;
  assign desc_idx_vld  = idx_vld_q;
  assign desc_idx_num  = idx_q;
  assign desc_scale    = scale_q;
  assign desc_len      = cnt_q;

  // R9: held descriptor is frozen and blocks input
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_disp) &&
      $stable(desc_len) && $stable(desc_base_num) && $stable(desc_idx_num));
  a_r9_no_input: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> !in_ready);
  // R10: release reopens input on the next cycle
  a_r10_reopen: assert property (@(posedge clk) disable iff (rst)
    desc_valid && desc_ready |=> in_ready && !desc_valid);
  // R4: RIP-relative form has neither base nor index and five bytes
  a_r4_rip_shape: assert property (@(posedge clk) disable iff (rst)
    desc_valid && desc_rip_rel |-> !desc_base_vld && !desc_idx_vld &&
      desc_len == CNT_W'(5));
  // R2: register operand is a single byte with no displacement
  a_r2_reg_shape: assert property (@(posedge clk) disable iff (rst)
    desc_valid && desc_is_reg |-> desc_len == CNT_W'(1) &&
      desc_disp == '0 && !desc_idx_vld);
  // R5: scale is always a single power of two
  a_r5_scale_pow2: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> $countones(desc_scale) == 1);
  // R3: lengths 4, 0 and above 6 cannot occur
  a_r3_len_legal: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> desc_len != '0 && desc_len != CNT_W'(4) &&
      desc_len <= CNT_W'(6));
  // R11: an idle cycle does not advance the parse
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid && !desc_valid |=> !desc_valid && $stable(desc_len));

endmodule

// File: tb/mrm_parser_test.sv
module mrm_parser_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        desc_valid;
  logic        desc_ready = 1'b0;
  logic        desc_is_reg, desc_rip_rel, desc_base_vld, desc_idx_vld;
  logic [3:0]  desc_base_num, desc_idx_num, desc_scale;
  logic [63:0] desc_disp;
  logic [2:0]  desc_len;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mrm_parser uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_is_reg(desc_is_reg), .desc_rip_rel(desc_rip_rel),
    .desc_base_vld(desc_base_vld), .desc_base_num(desc_base_num),
    .desc_idx_vld(desc_idx_vld), .desc_idx_num(desc_idx_num),
    .desc_scale(desc_scale), .desc_disp(desc_disp), .desc_len(desc_len)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  // Idle cycles carry junk on in_byte (R11).
  task automatic send(input logic [7:0] b, input int gap);
    in_valid = 1'b0;
    for (int k = 0; k < gap; k++) begin
      in_byte = ~b ^ 8'h3C;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_case(input logic [7:0] modrm, input logic [7:0] sib,
                          input logic [31:0] raw, input int gap, input int hold);
    logic [1:0] m;
    logic [2:0] r, ss, ix, bs;
    logic e_reg, e_rip, e_bv, e_iv, has_sib;
    logic [3:0] e_b, e_i, e_sc;
    int len;
    logic [63:0] e_disp;
    logic [2:0] e_cnt;
    string tag;
    m  = modrm[7:6]; r = modrm[2:0];
    ss = {1'b0, sib[7:6]}; ix = sib[5:3]; bs = sib[2:0];
    e_reg = 0; e_rip = 0; e_bv = 0; e_iv = 0; e_b = 0; e_i = 0; e_sc = 1;
    has_sib = 0;
    len = (m == 2'd1) ? 1 : (m == 2'd2) ? 4 : 0;
    if (m == 2'd3) begin
      tag = "R2"; e_reg = 1; e_bv = 1; e_b = {1'b0, r}; len = 0;
    end else if (r == 3'd4) begin
      has_sib = 1; tag = "R5";
      e_sc = 4'd1 << ss;
      e_iv = (ix != 3'd4); e_i = e_iv ? {1'b0, ix} : 4'd0;
      if (m == 2'd0 && bs == 3'd5) begin
        tag = "R6"; len = 4;
      end else begin
        e_bv = 1; e_b = {1'b0, bs};
      end
    end else if (m == 2'd0 && r == 3'd5) begin
      tag = "R4"; e_rip = 1; len = 4;
    end else begin
      tag = (m == 2'd1 && r == 3'd5) ? "R7" : "R3";
      e_bv = 1; e_b = {1'b0, r};
    end
    e_cnt = 3'(1 + (has_sib ? 1 : 0) + len);
    if (len == 1)      e_disp = {{56{raw[7]}}, raw[7:0]};
    else if (len == 4) e_disp = {{32{raw[31]}}, raw};
    else               e_disp = 64'd0;

    send(modrm, gap);
    if (has_sib) send(sib, gap);
    for (int k = 0; k < len; k++) send(raw[k*8 +: 8], gap);

    chk(tag, "desc_valid after last byte", {63'd0, desc_valid}, 64'd1);
    chk(tag, "fields {reg,rip,bv,base,iv,idx,scale,len}",
        {41'd0, desc_is_reg, desc_rip_rel, desc_base_vld, desc_base_num,
         desc_idx_vld, desc_idx_num, desc_scale, desc_len},
        {41'd0, e_reg, e_rip, e_bv, e_b, e_iv, e_i, e_sc, e_cnt});
    chk("R8", "displacement", desc_disp, e_disp);

    if (hold > 0) begin
      // R9: offer a byte while the descriptor is held; it must not be taken
      in_valid = 1'b1;
      in_byte  = 8'hC0;
      for (int k = 0; k < hold; k++) @(negedge clk);
      chk("R9", "held {valid,ready,len}", {59'd0, desc_valid, in_ready, desc_len},
          {59'd0, 1'b1, 1'b0, e_cnt});
      chk("R9", "held displacement", desc_disp, e_disp);
      in_valid = 1'b0;
    end
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
    chk("R10", "{desc_valid,in_ready} after accept", {62'd0, desc_valid, in_ready},
        64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "{in_ready,desc_valid} after reset", {62'd0, in_ready, desc_valid},
        64'd2);

    // R11: a mod=10 form stalls with idle junk between bytes
    send(8'h81, 0);
    in_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      in_byte = 8'hFF;
      @(negedge clk);
    end
    chk("R11", "{desc_valid,in_ready} during idle", {62'd0, desc_valid, in_ready},
        64'd1);
    for (int k = 0; k < 4; k++) send(8'(k + 1), 0);
    chk("R11", "length after idle stall", {61'd0, desc_len}, 64'd5);
    chk("R11", "displacement after idle stall", desc_disp, 64'h04030201);
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;

    // R7 corners: [rbp] as mod=01 with zero and negative 8-bit displacement
    run_case(8'h45, 8'h00, 32'h0000_0000, 0, 0);
    run_case(8'h45, 8'h00, 32'h0000_0080, 0, 1);
    // R8 corner: most negative 32-bit displacement
    run_case(8'h85, 8'h00, 32'h8000_0000, 0, 0);
    run_case(8'h05, 8'h00, 32'h7FFF_FFFF, 0, 0);

    // Sweep every ModR/M value that needs no SIB byte (R2, R3, R4, R7)
    for (int i = 0; i < 256; i++) begin
      if (i[7:6] == 2'd3 || i[2:0] != 3'd4)
        run_case(8'(i), 8'h00, 32'(i * 32'h9E3779B1) ^ 32'h5A5A0F0F,
                 (i % 3 == 0) ? 1 : 0, (i % 5 == 0) ? 2 : 0);
    end

    // Sweep every SIB value under each memory mod (R5, R6)
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 256; s++) begin
        run_case({2'(m), 3'(s), 3'b100}, 8'(s),
                 32'((s + 256 * m) * 32'h85EBCA6B) ^ 32'hC2B2AE35,
                 (s % 4 == 1) ? 1 : 0, (s % 7 == 0) ? 1 : 0);
      end
    end

    report;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    report;
  end

endmodule